// File: doc/BRIEF.md
# Parallel EEPROM Page Write Load Controller

This block is the write-side control of a byte-wide parallel EEPROM model. It watches the active-low chip-enable, write-enable and output-enable pins, together with a 15-bit address bus and an 8-bit data bus. It gathers between one and 64 bytes of a single page into a page latch. A byte-load inactivity timeout closes the load window. A fixed-length internal programming interval then copies the loaded bytes into a nonvolatile array, which is modelled here as a plain RAM.

The write strobe is active while both chip-enable and write-enable are low, so either pin can time a byte. All pins pass through a two-flop synchronizer before edge detection. Every time window counts cycles of the free-running system clock. An active-low protect input (`hold_ni`) blocks all access. Pulling it low while a page is being loaded or programmed aborts the operation. A busy output drives the open-drain ready/busy pad low from the first accepted strobe until the operation ends.

The array model keeps 2^`ARR_PAGE_W` pages, and page numbers wrap modulo that count. The programming interval must be longer than 64 cycles, because the array takes one byte per cycle from the start of programming.

Top module: `eeprom_page_loader`

## Requirements
- R1: Address bits [14:6] give the page and bits [5:0] give the byte offset. The page is captured at the first accepted strobe fall of a write cycle. Later bytes of that cycle go to the captured page, whatever their upper address bits are.
- R2: The write strobe is active while both `ce_ni` and `we_ni` are low, so either pin may be the one that toggles. The byte offset is taken when the strobe becomes active, and the data is taken when the strobe becomes inactive.
- R3: A further byte is accepted only if its strobe fall comes fewer than `LOAD_WIN_CYC` cycles after the previous accepted fall. A later strobe is ignored, and its byte is not written.
- R4: A write cycle takes at most 64 bytes. Any strobe after the 64th byte is ignored, and it leaves earlier bytes untouched.
- R5: Programming begins once the strobe has been inactive for `CLOSE_CYC` cycles after the last data byte. Programming lasts `PROG_CYC` cycles, and the block then returns to idle.
- R6: `busy_pull_o` is 0 after reset and while idle. It becomes 1 after the first accepted strobe and stays 1 until programming completes.
- R7: While `hold_ni` is low, no strobe is accepted and the array read port returns 8'h00. A fall of `hold_ni` during loading or programming aborts the operation and releases busy. Bytes that programming had not yet reached keep their old contents.
- R8: A strobe that occurs while `oe_ni` is low is ignored, and busy stays 0.
- R9: The array reads 8'hFF after reset. Offsets of a page that were not loaded in a write cycle keep their previous contents when the page is programmed.
- R10: Strobes that occur during programming are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running system clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_ni | input | 1 | Chip enable, active low, asynchronous |
| we_ni | input | 1 | Write enable, active low, asynchronous |
| oe_ni | input | 1 | Output enable, active low; a write needs it high |
| hold_ni | input | 1 | Protect/abort input, active low |
| addr_i | input | 15 | Byte address |
| data_i | input | 8 | Write data |
| busy_pull_o | output | 1 | 1 drives the open-drain ready/busy pad low |
| arr_raddr_i | input | 10 | Array model read address {page[3:0], offset} |
| arr_rdata_o | output | 8 | Array model read data, 0 while protected |

## Verification
The bench writes a second byte whose upper address bits differ from the first. A design that re-latched the page on every strobe would put that byte into the wrong page. Other stimuli target the window checks: a byte that arrives after the load window but before the close timeout, a 65th strobe on a full page, and a strobe during programming. A design that missed any of these would overwrite a byte that should have kept its value. The abort case drops `hold_ni` early in programming and expects a loaded high offset to stay erased while busy is released. The bench also measures the interval from the last strobe to the release of busy, which catches an off-by-many close or programming timer.

// File: rtl/eeprom_loader_pkg.sv
package eeprom_loader_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } ld_state_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int          N       = 4,
  parameter logic [N-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL[g];
        s2_q <= RST_VAL[g];
      end else begin
        s1_q <= async_i[g];
        s2_q <= s1_q;
      end
    end
    assign sync_o[g] = s2_q;
  end
endmodule

// File: rtl/page_latch.sv
module page_latch #(
  parameter int PAGE_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              ld_i,
  input  logic [PAGE_W-1:0] ld_off_i,
  input  logic [DATA_W-1:0] ld_data_i,
  input  logic [PAGE_W-1:0] rd_off_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_vld_o
);
  localparam int BYTES = 1 << PAGE_W;

  logic [DATA_W-1:0] byte_q [BYTES];
  logic [BYTES-1:0]  vld_q;

  for (genvar g = 0; g < BYTES; g++) begin : g_byte
    logic hit;
    assign hit = ld_i && (ld_off_i == PAGE_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        byte_q[g] <= '0;
        vld_q[g]  <= 1'b0;
      end else if (clr_i) begin
        vld_q[g] <= 1'b0;
      end else if (hit) begin
        byte_q[g] <= ld_data_i;
        vld_q[g]  <= 1'b1;
      end
    end
  end

  assign rd_data_o = byte_q[rd_off_i];
  assign rd_vld_o  = vld_q[rd_off_i];

  // R9
  clr_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr_i) |-> (vld_q == '0));
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
  parameter int          AW     = 10,
  parameter int          DW     = 8,
  parameter logic [DW-1:0] ERASED = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= ERASED;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = rd_en_i ? mem_q[raddr_i] : '0;

  // R7
  we_protect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> rd_en_i);
endmodule

// File: rtl/eeprom_page_loader.sv
module eeprom_page_loader
  import eeprom_loader_pkg::*;
#(
  parameter int          ADDR_W       = 15,
  parameter int          DATA_W       = 8,
  parameter int          PAGE_W       = 6,
  parameter int          ARR_PAGE_W   = 4,
  parameter int          LOAD_WIN_CYC = 40,
  parameter int          CLOSE_CYC    = 80,
  parameter int          PROG_CYC     = 200,
  parameter logic [DATA_W-1:0] ERASED = '1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         ce_ni,
  input  logic                         we_ni,
  input  logic                         oe_ni,
  input  logic                         hold_ni,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [DATA_W-1:0]            data_i,
  output logic                         busy_pull_o,
  input  logic [ARR_PAGE_W+PAGE_W-1:0] arr_raddr_i,
  output logic [DATA_W-1:0]            arr_rdata_o
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int PG_W       = ADDR_W - PAGE_W;
  localparam int ARR_AW     = ARR_PAGE_W + PAGE_W;
  localparam int GAP_W      = $clog2(LOAD_WIN_CYC + 1);
  localparam int IDL_W      = $clog2(CLOSE_CYC + 1);
  localparam int PRG_W      = $clog2(PROG_CYC + 1);
  localparam int CNT_W      = PAGE_W + 1;

  // synchronized pins: {hold, oe, we, ce}
  logic [3:0] pin_s;
  logic ce_s, we_s, oe_s, hold_s;

  pin_sync #(.N(4), .RST_VAL(4'b1111)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({hold_ni, oe_ni, we_ni, ce_ni}),
    .sync_o (pin_s)
  );
  assign {hold_s, oe_s, we_s, ce_s} = pin_s;

  logic strobe_low, strobe_low_q, wr_fall, wr_rise;
  assign strobe_low = ~ce_s & ~we_s;
  assign wr_fall    = strobe_low & ~strobe_low_q;
  assign wr_rise    = ~strobe_low & strobe_low_q;

  ld_state_e         state_q;
  logic [PG_W-1:0]   page_q;
  logic [PAGE_W-1:0] off_q;
  logic              pend_q;
  logic [GAP_W-1:0]  gap_q;
  logic [IDL_W-1:0]  idle_q;
  logic [PRG_W-1:0]  prog_q;
  logic [CNT_W-1:0]  nbytes_q;

  logic wr_ok, more_ok;
  assign wr_ok   = oe_s & hold_s;
  assign more_ok = wr_ok && !pend_q && (gap_q < GAP_W'(LOAD_WIN_CYC))
                   && (nbytes_q < CNT_W'(PAGE_BYTES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_low_q <= 1'b0;
    else         strobe_low_q <= strobe_low;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      page_q   <= '0;
      off_q    <= '0;
      pend_q   <= 1'b0;
      gap_q    <= '0;
      idle_q   <= '0;
      prog_q   <= '0;
      nbytes_q <= '0;
    end else begin
      if (gap_q != GAP_W'(LOAD_WIN_CYC)) gap_q <= gap_q + 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          pend_q <= 1'b0;
          if (wr_fall && wr_ok) begin
            state_q  <= ST_LOAD;
            page_q   <= addr_i[ADDR_W-1:PAGE_W];
            off_q    <= addr_i[PAGE_W-1:0];
            pend_q   <= 1'b1;
            gap_q    <= '0;
            idle_q   <= '0;
            nbytes_q <= CNT_W'(1);
          end
        end
        ST_LOAD: begin
          if (!hold_s) begin
            state_q <= ST_IDLE;
            pend_q  <= 1'b0;
          end else begin
            if (wr_fall && more_ok) begin
              off_q    <= addr_i[PAGE_W-1:0];
              pend_q   <= 1'b1;
              gap_q    <= '0;
              nbytes_q <= nbytes_q + 1'b1;
            end else if (wr_rise && pend_q) begin
              pend_q <= 1'b0;
            end
            if (strobe_low || pend_q) begin
              idle_q <= '0;
            end else if (idle_q == IDL_W'(CLOSE_CYC - 1)) begin
              state_q <= ST_PROG;
              prog_q  <= '0;
            end else begin
              idle_q <= idle_q + 1'b1;
            end
          end
        end
        ST_PROG: begin
          if (!hold_s || prog_q == PRG_W'(PROG_CYC - 1)) state_q <= ST_IDLE;
          else                                          prog_q  <= prog_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  logic              lat_ld, lat_clr, lat_vld;
  logic [DATA_W-1:0] lat_data;
  logic [PAGE_W-1:0] lat_rd_off;

  assign lat_clr    = (state_q == ST_IDLE);
  assign lat_ld     = (state_q == ST_LOAD) && hold_s && wr_rise && pend_q;
  assign lat_rd_off = prog_q[PAGE_W-1:0];

  page_latch #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (lat_clr),
    .ld_i     (lat_ld),
    .ld_off_i (off_q),
    .ld_data_i(data_i),
    .rd_off_i (lat_rd_off),
    .rd_data_o(lat_data),
    .rd_vld_o (lat_vld)
  );

  // one byte per cycle from the start of programming
  logic              arr_we;
  logic [ARR_AW-1:0] arr_waddr;
  assign arr_we    = (state_q == ST_PROG) && hold_s && lat_vld
                     && (int'(prog_q) < PAGE_BYTES);
  assign arr_waddr = {page_q[ARR_PAGE_W-1:0], lat_rd_off};

  eeprom_array #(.AW(ARR_AW), .DW(DATA_W), .ERASED(ERASED)) u_array (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (arr_we),
    .waddr_i(arr_waddr),
    .wdata_i(lat_data),
    .rd_en_i(hold_s),
    .raddr_i(arr_raddr_i),
    .rdata_o(arr_rdata_o)
  );

  assign busy_pull_o = (state_q != ST_IDLE);

  // R6
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_pull_o) |-> $past(wr_fall && oe_s && hold_s));
  // R7
  hold_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_s |=> !busy_pull_o);
  // R1
  page_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOAD && $past(state_q) == ST_LOAD) |-> $stable(page_q));
  // R5
  close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PROG && $past(state_q) == ST_LOAD) |-> $past(!strobe_low && !pend_q));
  // R4
  nbytes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nbytes_q <= CNT_W'(PAGE_BYTES));
  // R10
  prog_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PROG) |=> !lat_ld);
endmodule

// File: tb/eeprom_page_loader_bench.sv
module eeprom_page_loader_bench;
  localparam int CLOSE = 80;
  localparam int PROG  = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, hold_n = 1'b1;
  logic [14:0] addr = '0;
  logic [7:0]  data = '0;
  logic        busy;
  logic [9:0]  raddr = '0;
  logic [7:0]  rdata;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  eeprom_page_loader #(.LOAD_WIN_CYC(40), .CLOSE_CYC(CLOSE), .PROG_CYC(PROG)) u_eeprom_page_loader (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_ni(we_n), .oe_ni(oe_n),
    .hold_ni(hold_n), .addr_i(addr), .data_i(data), .busy_pull_o(busy),
    .arr_raddr_i(raddr), .arr_rdata_o(rdata)
  );

  typedef struct {
    logic [9:0] a;
    logic [7:0] d;
    string      req;
  } exp_t;
  exp_t exp_q[$];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(int pg, int off, logic [7:0] d, string req);
    exp_t e;
    e.a = {pg[3:0], off[5:0]};
    e.d = d;
    e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: compares array contents with queued expectations
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() != 0) begin
        exp_t e;
        e = exp_q.pop_front();
        raddr = e.a;
        #1;
        chk(e.req, {24'h0, rdata}, {24'h0, e.d});
      end
    end
  end

  function automatic logic [14:0] mk(int pg, int off);
    return {pg[8:0], off[5:0]};
  endfunction

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // by_ce: chip enable times the strobe, write enable held low
  task automatic begin_page(bit by_ce);
    @(negedge clk);
    if (by_ce) we_n = 1'b0;
    else       ce_n = 1'b0;
    idle(3);
  endtask

  task automatic end_page();
    @(negedge clk);
    ce_n = 1'b1;
    we_n = 1'b1;
  endtask

  task automatic wr_byte(logic [14:0] a, logic [7:0] d, bit by_ce);
    @(negedge clk);
    addr = a;
    data = d;
    idle(2);
    if (by_ce) ce_n = 1'b0;
    else       we_n = 1'b0;
    idle(8);
    if (by_ce) ce_n = 1'b1;
    else       we_n = 1'b1;
    idle(6);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 3000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    int n;
    idle(5);
    rst_n = 1'b1;
    idle(4);
    chk("R6 busy after reset", {31'h0, busy}, 32'h0);
    push(0, 0, 8'hFF, "R9 erased after reset");
    drain();

    // WE-timed single byte
    begin_page(1'b0);
    wr_byte(mk(1, 5), 8'h3C, 1'b0);
    chk("R6 busy after first strobe", {31'h0, busy}, 32'h1);
    end_page();
    wait_idle(n);
    chk("R5 close+program interval", {31'h0, (n >= CLOSE + PROG - 14) && (n <= CLOSE + PROG + 4)}, 32'h1);
    push(1, 5, 8'h3C, "R2 we-timed byte");
    push(1, 4, 8'hFF, "R9 unloaded neighbour low");
    push(1, 6, 8'hFF, "R9 unloaded neighbour high");
    drain();

    // CE-timed bytes, second one carries a foreign page number
    begin_page(1'b1);
    wr_byte(mk(2, 5), 8'h55, 1'b1);
    wr_byte(mk(9, 6), 8'h66, 1'b1);
    wr_byte(mk(2, 7), 8'h77, 1'b1);
    end_page();
    wait_idle(n);
    push(2, 5, 8'h55, "R2 ce-timed byte");
    push(2, 6, 8'h66, "R1 captured page used");
    push(2, 7, 8'h77, "R1 third byte");
    push(9, 6, 8'hFF, "R1 foreign page untouched");
    drain();

    // output enable low blocks writes
    @(negedge clk);
    oe_n = 1'b0;
    idle(4);
    begin_page(1'b0);
    wr_byte(mk(4, 0), 8'hAB, 1'b0);
    chk("R8 busy stays low", {31'h0, busy}, 32'h0);
    end_page();
    @(negedge clk);
    oe_n = 1'b1;
    idle(CLOSE + PROG + 20);
    chk("R8 still idle", {31'h0, busy}, 32'h0);
    push(4, 0, 8'hFF, "R8 byte not written");
    drain();

    // late byte outside load window
    begin_page(1'b0);
    wr_byte(mk(7, 1), 8'hA1, 1'b0);
    idle(50);
    wr_byte(mk(7, 2), 8'hA2, 1'b0);
    end_page();
    wait_idle(n);
    push(7, 1, 8'hA1, "R3 in-window byte");
    push(7, 2, 8'hFF, "R3 late byte ignored");
    drain();

    // full page plus one extra strobe
    begin_page(1'b0);
    for (int i = 0; i < 64; i++) wr_byte(mk(3, i), 8'(i) ^ 8'h5A, 1'b0);
    wr_byte(mk(3, 0), 8'h00, 1'b0);
    end_page();
    wait_idle(n);
    for (int i = 0; i < 64; i++) push(3, i, 8'(i) ^ 8'h5A, "R4 full page byte");
    drain();

    // strobe during programming
    begin_page(1'b0);
    wr_byte(mk(6, 2), 8'h77, 1'b0);
    end_page();
    idle(CLOSE + 20);
    begin_page(1'b0);
    wr_byte(mk(6, 3), 8'h99, 1'b0);
    end_page();
    wait_idle(n);
    chk("R10 programming completes", {31'h0, busy}, 32'h0);
    push(6, 2, 8'h77, "R10 loaded byte kept");
    push(6, 3, 8'hFF, "R10 strobe during program ignored");
    drain();

    // abort early in programming
    begin_page(1'b0);
    wr_byte(mk(5, 0), 8'h11, 1'b0);
    wr_byte(mk(5, 60), 8'h22, 1'b0);
    end_page();
    idle(CLOSE + 10);
    @(negedge clk);
    hold_n = 1'b0;
    idle(5);
    chk("R7 abort releases busy", {31'h0, busy}, 32'h0);
    push(5, 0, 8'h00, "R7 read inhibited");
    drain();
    begin_page(1'b0);
    wr_byte(mk(8, 1), 8'hC3, 1'b0);
    chk("R7 write while protected", {31'h0, busy}, 32'h0);
    end_page();
    @(negedge clk);
    hold_n = 1'b1;
    idle(CLOSE + PROG + 20);
    chk("R7 stays idle after protect", {31'h0, busy}, 32'h0);
    push(5, 0, 8'h11, "R7 byte programmed before abort");
    push(5, 60, 8'hFF, "R7 byte cut off by abort");
    push(8, 1, 8'hFF, "R7 protected write dropped");
    drain();

    summary();
  end
endmodule